// File: doc/BRIEF.md
# Bank-Switchable Dual-Port Memory

This block is a synchronous dual-port memory split into four equal banks. Each bank has one owner at a time, either the left port or the right port, and a dedicated owner input per bank sets which. Each port carries its own address, write data, read data, read/write line, output enable, a pair of chip selects and two byte enables. A two-bit bank field on each port chooses one of the four banks. The access goes ahead only when that bank currently belongs to the requesting port.

The usual use is a pair of processors sharing memory. Each processor works in the banks it holds. The system hands a filled bank to the other side by flipping that bank's owner input, and the contents then become visible to the new owner. The bank depth is a parameter, so the block can be simulated at a small size.

Top module: `bank_dpram`

## Requirements
- R1: While `rst` is high, and on the first clock after it, both read data outputs are zero.
- R2: `bank_owner[k]` = 0 gives bank k to the left port and 1 gives it to the right port. Storage is shared, so data written by one port can be read by the other port after ownership is handed over.
- R3: The two-bit bank field (0 to 3) selects one of four independent banks. Equal word addresses in different banks hold separate data.
- R4: A port is selected only when its chip select 0 is low and its chip select 1 is high. An unselected port writes nothing, and its next read data is zero.
- R5: The read/write line is high for a read and low for a write. The read data output in the cycle after a write is zero.
- R6: Byte enables are active low. The upper enable governs bits 15:8 and the lower enable governs bits 7:0. A write changes only the enabled lanes.
- R7: On a read, any lane whose byte enable is high returns zero.
- R8: A read with the output enable high returns zero. The output enable has no effect on writes.
- R9: A write to a bank the port does not own leaves the memory unchanged.
- R10: A read from a bank the port does not own returns zero.
- R11: Read data is registered and appears on the clock edge that follows the address.
- R12: The two ports work at the same time and independently in banks they each own. No bank is ever written by both ports in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_owner | input | 4 | Owner per bank: 0 means left, 1 means right |
| l_cs0_n | input | 1 | Left chip select 0, active low |
| l_cs1 | input | 1 | Left chip select 1, active high |
| l_rw | input | 1 | Left read (1) or write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper byte enable, active low |
| l_lb_n | input | 1 | Left lower byte enable, active low |
| l_bank | input | 2 | Left bank field |
| l_addr | input | BANK_AW | Left word address within the bank |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left registered read data |
| r_cs0_n | input | 1 | Right chip select 0, active low |
| r_cs1 | input | 1 | Right chip select 1, active high |
| r_rw | input | 1 | Right read (1) or write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper byte enable, active low |
| r_lb_n | input | 1 | Right lower byte enable, active low |
| r_bank | input | 2 | Right bank field |
| r_addr | input | BANK_AW | Right word address within the bank |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right registered read data |

## Verification
The directed patterns each target one behaviour:
- Writing one address in all four banks shows whether the bank field is decoded correctly.
- Upper-only and lower-only writes and reads show whether the two byte lanes stay separate.
- Handing a bank over and then reading it from the other side shows whether the owner input routes both ports to the same storage.
- Hitting a foreign bank shows whether ownership blocks both writes and reads.

Random traffic then mixes chip-select combinations, output-enable levels, lane masks and ownership that changes often. This separates a port that is gated wrongly from a bank that is routed wrongly. Every result is compared against a bench model of the four banks.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;
    localparam int BSEL_W = 2;
    localparam int BANKS  = 1 << BSEL_W;

    typedef enum logic {
        OWN_LEFT  = 1'b0,
        OWN_RIGHT = 1'b1
    } owner_e;

    // One port's decoded request, already gated by selection and ownership
    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [LANES-1:0]  lane;   // bit 1 = upper byte, bit 0 = lower byte
        logic [BSEL_W-1:0] bank;
    } acc_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] lane);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{lane[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/bdp_port_ctrl.sv
module bdp_port_ctrl
    import bdp_pkg::*;
#(
    parameter owner_e SIDE = OWN_LEFT
) (
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              rw,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [BSEL_W-1:0] bank,
    input  logic [BANKS-1:0]  owner,
    output acc_t              acc
);
    logic selected;
    logic owned;

    always_comb begin
        selected = !cs0_n && cs1;
        owned    = (owner[bank] == SIDE);
        acc.bank = bank;
        acc.lane = {!ub_n, !lb_n};
        acc.wr   = selected && owned && !rw;
        acc.rd   = selected && owned && rw && !oe_n;
    end

endmodule

// File: rtl/bdp_bank.sv
module bdp_bank
    import bdp_pkg::*;
#(
    parameter int BANK_AW = 4,
    parameter int IDX     = 0
) (
    input  logic               clk,
    input  logic               owner,
    input  acc_t               l_acc,
    input  acc_t               r_acc,
    input  logic [BANK_AW-1:0] l_addr,
    input  logic [BANK_AW-1:0] r_addr,
    input  logic [DATA_W-1:0]  l_wdata,
    input  logic [DATA_W-1:0]  r_wdata,
    output logic [DATA_W-1:0]  q
);
    localparam int DEPTH = 1 << BANK_AW;

    logic [DATA_W-1:0]  mem [DEPTH];
    acc_t               act;
    logic [BANK_AW-1:0] addr;
    logic [DATA_W-1:0]  wdata;
    logic               we;

    // Only the owning port ever reaches this bank
    always_comb begin
        if (owner == OWN_RIGHT) begin
            act   = r_acc;
            addr  = r_addr;
            wdata = r_wdata;
        end else begin
            act   = l_acc;
            addr  = l_addr;
            wdata = l_wdata;
        end
        we = act.wr && (act.bank == BSEL_W'(IDX));
    end

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (act.lane[i]) begin
                    mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign q = mem[addr];

endmodule

// File: rtl/bdp_rd_port.sv
module bdp_rd_port
    import bdp_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  acc_t                         acc,
    input  logic [BANKS-1:0][DATA_W-1:0] bank_q,
    output logic [DATA_W-1:0]            rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (acc.rd) begin
            rdata <= bank_q[acc.bank] & lane_mask(acc.lane);
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/bank_dpram.sv
module bank_dpram
    import bdp_pkg::*;
#(
    parameter int BANK_AW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         bank_owner,
    input  logic               l_cs0_n,
    input  logic               l_cs1,
    input  logic               l_rw,
    input  logic               l_oe_n,
    input  logic               l_ub_n,
    input  logic               l_lb_n,
    input  logic [1:0]         l_bank,
    input  logic [BANK_AW-1:0] l_addr,
    input  logic [15:0]        l_wdata,
    output logic [15:0]        l_rdata,
    input  logic               r_cs0_n,
    input  logic               r_cs1,
    input  logic               r_rw,
    input  logic               r_oe_n,
    input  logic               r_ub_n,
    input  logic               r_lb_n,
    input  logic [1:0]         r_bank,
    input  logic [BANK_AW-1:0] r_addr,
    input  logic [15:0]        r_wdata,
    output logic [15:0]        r_rdata
);
    acc_t                         l_acc;
    acc_t                         r_acc;
    logic [BANKS-1:0][DATA_W-1:0] bank_q;

    bdp_port_ctrl #(.SIDE(OWN_LEFT)) u_lctl (
        .cs0_n(l_cs0_n), .cs1(l_cs1), .rw(l_rw), .oe_n(l_oe_n),
        .ub_n(l_ub_n), .lb_n(l_lb_n), .bank(l_bank), .owner(bank_owner),
        .acc(l_acc)
    );

    bdp_port_ctrl #(.SIDE(OWN_RIGHT)) u_rctl (
        .cs0_n(r_cs0_n), .cs1(r_cs1), .rw(r_rw), .oe_n(r_oe_n),
        .ub_n(r_ub_n), .lb_n(r_lb_n), .bank(r_bank), .owner(bank_owner),
        .acc(r_acc)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bdp_bank #(.BANK_AW(BANK_AW), .IDX(b)) u_bank (
            .clk(clk), .owner(bank_owner[b]),
            .l_acc(l_acc), .r_acc(r_acc),
            .l_addr(l_addr), .r_addr(r_addr),
            .l_wdata(l_wdata), .r_wdata(r_wdata),
            .q(bank_q[b])
        );
    end

    bdp_rd_port u_lrd (
        .clk(clk), .rst(rst), .acc(l_acc), .bank_q(bank_q), .rdata(l_rdata)
    );

    bdp_rd_port u_rrd (
        .clk(clk), .rst(rst), .acc(r_acc), .bank_q(bank_q), .rdata(r_rdata)
    );

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker
    import bdp_pkg::*;
#(
    parameter int BANK_AW = 4
) (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  bank_owner,
    input logic        l_cs0_n,
    input logic        l_cs1,
    input logic        l_rw,
    input logic        l_oe_n,
    input logic        l_ub_n,
    input logic [1:0]  l_bank,
    input logic [15:0] l_rdata,
    input logic        r_cs0_n,
    input logic        r_cs1,
    input logic        r_rw,
    input logic        r_oe_n,
    input logic        r_lb_n,
    input logic [1:0]  r_bank,
    input logic [15:0] r_rdata,
    input acc_t        l_acc,
    input acc_t        r_acc
);
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (l_rdata == 16'h0 && r_rdata == 16'h0));

    p_deselect_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $past(l_cs0_n || !l_cs1) |-> l_rdata == 16'h0);

    p_write_cycle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!r_rw) |-> r_rdata == 16'h0);

    p_upper_lane_r7: assert property (@(posedge clk) disable iff (rst)
        $past(l_ub_n) |-> l_rdata[15:8] == 8'h0);

    p_lower_lane_r7: assert property (@(posedge clk) disable iff (rst)
        $past(r_lb_n) |-> r_rdata[7:0] == 8'h0);

    p_oe_gate_r8: assert property (@(posedge clk) disable iff (rst)
        $past(l_oe_n) |-> l_rdata == 16'h0);

    p_write_owned_r9: assert property (@(posedge clk) disable iff (rst)
        l_acc.wr |-> bank_owner[l_acc.bank] == OWN_LEFT);

    p_foreign_read_r10: assert property (@(posedge clk) disable iff (rst)
        $past(bank_owner[r_bank] == OWN_LEFT) |-> r_rdata == 16'h0);

    p_single_writer_r12: assert property (@(posedge clk) disable iff (rst)
        (l_acc.wr && r_acc.wr) |-> l_acc.bank != r_acc.bank);

endmodule

bind bank_dpram bdp_checker #(.BANK_AW(BANK_AW)) u_chk (
    .clk(clk), .rst(rst), .bank_owner(bank_owner),
    .l_cs0_n(l_cs0_n), .l_cs1(l_cs1), .l_rw(l_rw), .l_oe_n(l_oe_n),
    .l_ub_n(l_ub_n), .l_bank(l_bank), .l_rdata(l_rdata),
    .r_cs0_n(r_cs0_n), .r_cs1(r_cs1), .r_rw(r_rw), .r_oe_n(r_oe_n),
    .r_lb_n(r_lb_n), .r_bank(r_bank), .r_rdata(r_rdata),
    .l_acc(l_acc), .r_acc(r_acc)
);

// File: tb/test_bank_dpram.sv
`timescale 1ns/1ps
module test_bank_dpram;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] owner = 4'h0;

    // index 0 = left port, 1 = right port
    logic          cs0_n [2];
    logic          cs1   [2];
    logic          rw    [2];
    logic          oe_n  [2];
    logic          ub_n  [2];
    logic          lb_n  [2];
    logic [1:0]    bank  [2];
    logic [AW-1:0] addr  [2];
    logic [15:0]   wdata [2];
    logic [15:0]   l_rdata, r_rdata;

    logic [15:0] ref_mem [4][DEPTH];
    logic [15:0] exp_q [2];
    string       tag_q [2];
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bank_dpram #(.BANK_AW(AW)) i_bank_dpram (
        .clk(clk), .rst(rst), .bank_owner(owner),
        .l_cs0_n(cs0_n[0]), .l_cs1(cs1[0]), .l_rw(rw[0]), .l_oe_n(oe_n[0]),
        .l_ub_n(ub_n[0]), .l_lb_n(lb_n[0]), .l_bank(bank[0]), .l_addr(addr[0]),
        .l_wdata(wdata[0]), .l_rdata(l_rdata),
        .r_cs0_n(cs0_n[1]), .r_cs1(cs1[1]), .r_rw(rw[1]), .r_oe_n(oe_n[1]),
        .r_ub_n(ub_n[1]), .r_lb_n(lb_n[1]), .r_bank(bank[1]), .r_addr(addr[1]),
        .r_wdata(wdata[1]), .r_rdata(r_rdata)
    );

    function automatic logic [15:0] lanes(input int p);
        return {{8{!ub_n[p]}}, {8{!lb_n[p]}}};
    endfunction

    function automatic logic is_sel(input int p);
        return !cs0_n[p] && cs1[p];
    endfunction

    function automatic logic is_owned(input int p);
        return owner[bank[p]] == p[0];
    endfunction

    function automatic logic [15:0] expect_rd(input int p);
        if (is_sel(p) && is_owned(p) && rw[p] && !oe_n[p])
            return ref_mem[bank[p]][addr[p]] & lanes(p);
        return 16'h0;
    endfunction

    function automatic string classify(input int p);
        if (!is_sel(p))  return "R4";
        if (!is_owned(p)) return rw[p] ? "R10" : "R9";
        if (!rw[p])      return "R5";
        if (oe_n[p])     return "R8";
        if (ub_n[p] || lb_n[p]) return "R7";
        return "R11";
    endfunction

    task automatic chk(input string tag, input string side,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s port: got %h expected %h", tag, side, act, exp);
        end
    endtask

    task automatic idle(input int p);
        cs0_n[p] = 1'b1; cs1[p] = 1'b0; rw[p] = 1'b1; oe_n[p] = 1'b1;
        ub_n[p] = 1'b1; lb_n[p] = 1'b1; bank[p] = 2'd0; addr[p] = '0;
        wdata[p] = 16'h0;
    endtask

    task automatic acc(input int p, input logic w, input logic [1:0] b,
                       input int a, input logic [15:0] d,
                       input logic u_n = 1'b0, input logic l_n = 1'b0,
                       input logic o_n = 1'b0);
        cs0_n[p] = 1'b0; cs1[p] = 1'b1; rw[p] = !w; oe_n[p] = o_n;
        ub_n[p] = u_n; lb_n[p] = l_n; bank[p] = b; addr[p] = AW'(a);
        wdata[p] = d;
    endtask

    // Inputs are already set (at a falling edge): compute, clock, check.
    task automatic step(input string tl, input string tr);
        for (int p = 0; p < 2; p++) exp_q[p] = expect_rd(p);
        for (int p = 0; p < 2; p++) begin
            if (is_sel(p) && is_owned(p) && !rw[p])
                ref_mem[bank[p]][addr[p]] =
                    (ref_mem[bank[p]][addr[p]] & ~lanes(p)) | (wdata[p] & lanes(p));
        end
        @(posedge clk);
        @(negedge clk);
        chk(tl, "left", l_rdata, exp_q[0]);
        chk(tr, "right", r_rdata, exp_q[1]);
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        idle(0); idle(1);

        // R1: reset clears outputs even with read requests pending
        acc(0, 1'b0, 2'd0, 0, 16'h0);
        acc(1, 1'b0, 2'd0, 0, 16'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "left", l_rdata, 16'h0);
        chk("R1", "right", r_rdata, 16'h0);
        rst = 1'b0;
        idle(0); idle(1);

        // Fill every bank from the left port
        owner = 4'h0;
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < DEPTH; a++) begin
                acc(0, 1'b1, 2'(b), a, 16'(b * 256 + a * 3 + 16'h1000));
                step("R5", "R4");
            end
        end

        // R3 + R11: same address in all four banks, one-cycle read
        for (int b = 0; b < 4; b++) begin
            acc(0, 1'b1, 2'(b), 5, 16'hB000 + 16'(b));
            step("R3", "R4");
        end
        for (int b = 0; b < 4; b++) begin
            acc(0, 1'b0, 2'(b), 5, 16'h0);
            step("R3", "R4");
        end
        acc(0, 1'b0, 2'd2, 5, 16'h0);
        step("R11", "R4");

        // R2: hand bank 1 to the right port; right sees left's data, left blocked
        owner = 4'b0010;
        acc(1, 1'b0, 2'd1, 5, 16'h0);
        acc(0, 1'b0, 2'd1, 5, 16'h0);
        step("R10", "R2");

        // R9: left writes the bank it lost; right reads it unchanged
        acc(0, 1'b1, 2'd1, 5, 16'hDEAD);
        idle(1);
        step("R9", "R4");
        idle(0);
        acc(1, 1'b0, 2'd1, 5, 16'h0);
        step("R4", "R9");

        // R6: upper-only then lower-only writes from the right port
        acc(1, 1'b1, 2'd1, 7, 16'hAA55, 1'b0, 1'b1);
        step("R4", "R6");
        acc(1, 1'b1, 2'd1, 8, 16'h33CC, 1'b1, 1'b0);
        step("R4", "R6");
        acc(1, 1'b0, 2'd1, 7, 16'h0);
        step("R4", "R6");
        acc(1, 1'b0, 2'd1, 8, 16'h0);
        step("R4", "R6");

        // R7: read with lower lane disabled; R8: output enable high
        acc(1, 1'b0, 2'd1, 7, 16'h0, 1'b0, 1'b1);
        step("R4", "R7");
        acc(1, 1'b0, 2'd1, 7, 16'h0, 1'b0, 1'b0, 1'b1);
        step("R4", "R8");
        // R8: output enable high does not block a write
        acc(1, 1'b1, 2'd1, 9, 16'h5A5A, 1'b0, 1'b0, 1'b1);
        step("R4", "R8");
        acc(1, 1'b0, 2'd1, 9, 16'h0);
        step("R4", "R8");

        // R4: each chip select alone is not enough
        acc(0, 1'b1, 2'd0, 2, 16'hFFFF); cs0_n[0] = 1'b1;
        step("R4", "R4");
        acc(0, 1'b1, 2'd0, 2, 16'hEEEE); cs1[0] = 1'b0;
        step("R4", "R4");
        acc(0, 1'b0, 2'd0, 2, 16'h0);
        step("R4", "R4");

        // R12: both ports active in their own banks in the same cycle
        owner = 4'b1100;
        acc(0, 1'b1, 2'd0, 1, 16'h1111);
        acc(1, 1'b1, 2'd3, 1, 16'h3333);
        step("R12", "R12");
        acc(0, 1'b0, 2'd0, 1, 16'h0);
        acc(1, 1'b0, 2'd3, 1, 16'h0);
        step("R12", "R12");

        // Random traffic with ownership changes
        for (int i = 0; i < 4000; i++) begin
            if (i % 16 == 0) owner = 4'($urandom);
            for (int p = 0; p < 2; p++) begin
                cs0_n[p] = ($urandom % 8) == 0;
                cs1[p]   = ($urandom % 8) != 0;
                rw[p]    = $urandom % 2;
                oe_n[p]  = ($urandom % 6) == 0;
                ub_n[p]  = ($urandom % 4) == 0;
                lb_n[p]  = ($urandom % 4) == 0;
                bank[p]  = 2'($urandom);
                addr[p]  = AW'($urandom);
                wdata[p] = 16'($urandom);
                tag_q[p] = classify(p);
            end
            step(tag_q[0], tag_q[1]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule